// File: doc/BRIEF.md
# Flash Sector-Erase Command Sequencer

This block sits on the write side of a NOR-style flash bus and interprets the commands that arrive there. It watches the chip-enable and write-enable strobes. It captures the address when a write begins and the data byte when it ends, and it steps through the six-write unlock sequence that arms a sector erase. Each sector-erase write marks one sector in a selection mask. Further sector writes can follow with no new unlock sequence, and each new write restarts an accept window. When the window runs out, the erase of every marked, unprotected sector starts. A cycle counter stands in for the physical erase time.

While the erase is pending or running, the read path returns status instead of array data. Bit 7 reads 0 and bit 6 flips on every status read. The ready/busy output is held low. During the erase only the suspend command is recognised. Suspend freezes the erase counter and hands the read path back to the array. Resume continues the count from where it stopped. On completion the block drops the selection and returns to plain array reads.

Top module: `flash_erase_seq`

## Requirements
- R1: After reset, `ry_by_n` is 1, `erase_run` is 0, `erase_sel` is all zero and `dout` equals `array_dq`.
- R2: The writes AAh@555h, 55h@2AAh, 80h@555h, AAh@555h, 55h@2AAh and then 30h to any address select the sector numbered by the top log2(NSECT) address bits and drive `ry_by_n` low. The address is taken when a write strobe begins (both enables low) and the data is taken when it ends.
- R3: A write whose address or data does not match the next expected unlock step returns the sequencer to read mode: nothing is selected and `ry_by_n` stays 1.
- R4: After the first sector write, each further 30h write adds its sector to `erase_sel`, in any order and in any number.
- R5: The erase starts (`erase_run` goes to 1) about CLK_MHZ*WIN_US cycles after the last write ends. Any write strobe that begins inside that window restarts the full window.
- R6: A 30h write that arrives after the erase has started does not change `erase_sel`.
- R7: While `ry_by_n` is 0, `dout[7]` reads 0, `dout[5:0]` follows `array_dq`, and `dout[6]` inverts after every `rd_stb` pulse. Its value after reset is 0.
- R8: After ERASE_CYC cycles of running erase, the block returns to read mode: `ry_by_n` is 1, `erase_run` is 0, `erase_sel` is zero and `dout` equals `array_dq`.
- R9: A sector whose `wp_mask` bit is set never appears in `erase_sel`.
- R10: B0h written during the erase suspends it. `erase_run` goes to 0, `ry_by_n` goes to 1 and `dout` equals `array_dq`, while the selection is kept and the erase count is frozen. A later 30h resumes with the remaining count.
- R11: During the erase, writes other than B0h are ignored, including a complete new unlock sequence. The erase still ends on its original schedule.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ce_n | input | 1 | Chip enable, active low |
| we_n | input | 1 | Write enable, active low |
| addr | input | AW | Bus address |
| wdata | input | 8 | Write data byte |
| rd_stb | input | 1 | One-cycle pulse per read access |
| array_dq | input | 8 | Data from the array read path |
| wp_mask | input | NSECT | Write-protect bit per sector |
| dout | output | 8 | Read data: array data or status |
| ry_by_n | output | 1 | Low while an erase is pending or running |
| erase_run | output | 1 | High while the erase counter advances |
| erase_sel | output | NSECT | Sectors selected for erase, protection applied |

## Verification
The bench corrupts the unlock sequence at a late step. A design that only checked the data byte, or that kept partial progress, would arm an erase there. It restarts the accept window with one more sector write at a point where a non-restarting timer would already have started the erase, so such a design shows `erase_run` high too early. It replays a full unlock and sector write during the erase, which a design that kept decoding would add to the selection or re-arm with. It also holds a suspend well past the full erase length. A counter that kept running would then finish at once on resume, where it should have kept running for the remaining cycles. The address is changed in the middle of each write strobe, so a design that captured the address at the end of the strobe would select the wrong sector.

// File: rtl/flash_erase_pkg.sv
// Shared definitions for the sector-erase sequencer.
// Assumes: command bytes are 8 bits wide.
package flash_erase_pkg;

    typedef enum logic [3:0] {
        ST_READ,
        ST_U1,
        ST_U2,
        ST_SETUP,
        ST_U3,
        ST_U4,
        ST_WINDOW,
        ST_ERASE,
        ST_SUSP
    } seq_st_t;

    localparam logic [7:0] CMD_KEY1    = 8'hAA;
    localparam logic [7:0] CMD_KEY2    = 8'h55;
    localparam logic [7:0] CMD_ARM     = 8'h80;
    localparam logic [7:0] CMD_SECTOR  = 8'h30;
    localparam logic [7:0] CMD_SUSPEND = 8'hB0;

endpackage

// File: rtl/flash_bus_strobe.sv
// Write-strobe detector. A write is active while both enables are low.
// It gives a registered pulse when a write begins, with the address
// captured at that edge, and one when it ends, with the data captured there.
// Assumes: the enables are synchronous to clk.
module flash_bus_strobe #(
    parameter int AW = 12
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ce_n,
    input  logic          we_n,
    input  logic [AW-1:0] addr,
    input  logic [7:0]    wdata,
    output logic          stb_start,
    output logic          stb_end,
    output logic [AW-1:0] cap_addr,
    output logic [7:0]    cap_data
);

    logic act;
    logic act_q;

    assign act = ~ce_n & ~we_n;

    // Track the strobe and latch address at its start, data at its end.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            act_q     <= 1'b0;
            stb_start <= 1'b0;
            stb_end   <= 1'b0;
            cap_addr  <= '0;
            cap_data  <= '0;
        end else begin
            act_q     <= act;
            stb_start <= act & ~act_q;
            stb_end   <= ~act & act_q;
            if (act && !act_q) cap_addr <= addr;
            if (!act && act_q) cap_data <= wdata;
        end
    end

endmodule

// File: rtl/flash_down_timer.sv
// Loadable down-counter with a run enable. done is high at zero.
// Assumes: MAX >= 2.
module flash_down_timer #(
    parameter int MAX = 100
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load,
    input  logic run,
    output logic done
);

    localparam int CW = $clog2(MAX + 1);

    logic [CW-1:0] cnt;

    // Reload on request, otherwise count down while enabled.
    always_ff @(posedge clk) begin
        if (!rst_n)                cnt <= '0;
        else if (load)             cnt <= CW'(MAX - 1);
        else if (run && cnt != '0) cnt <= cnt - 1'b1;
    end

    assign done = (cnt == '0);

endmodule

// File: rtl/flash_cmd_fsm.sv
// Command interpreter: unlock steps, sector collection, accept window,
// erase run and suspend. Acts on the end of each write strobe.
// Assumes: NSECT is a power of two; the sector index is the top address bits.
module flash_cmd_fsm
    import flash_erase_pkg::*;
#(
    parameter int          AW     = 12,
    parameter int          NSECT  = 8,
    parameter logic [11:0] UNL_A1 = 12'h555,
    parameter logic [11:0] UNL_A2 = 12'h2AA
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             stb_start,
    input  logic             stb_end,
    input  logic [AW-1:0]    cap_addr,
    input  logic [7:0]       cap_data,
    input  logic             win_done,
    input  logic             ers_done,
    output seq_st_t          state,
    output logic [NSECT-1:0] sel,
    output logic             win_load,
    output logic             ers_load
);

    localparam int SW = $clog2(NSECT);

    seq_st_t          st_nxt;
    logic [NSECT-1:0] sel_nxt;
    logic [NSECT-1:0] sec_bit;
    logic             at_a1;
    logic             at_a2;

    assign sec_bit = {{(NSECT-1){1'b0}}, 1'b1} << cap_addr[AW-1 -: SW];
    assign at_a1   = (cap_addr == AW'(UNL_A1));
    assign at_a2   = (cap_addr == AW'(UNL_A2));

    // Next-state decode for the command sequence.
    always_comb begin
        st_nxt   = state;
        sel_nxt  = sel;
        win_load = 1'b0;
        ers_load = 1'b0;
        case (state)
            ST_READ:  if (stb_end) st_nxt = (at_a1 && cap_data == CMD_KEY1) ? ST_U1 : ST_READ;
            ST_U1:    if (stb_end) st_nxt = (at_a2 && cap_data == CMD_KEY2) ? ST_U2 : ST_READ;
            ST_U2:    if (stb_end) st_nxt = (at_a1 && cap_data == CMD_ARM) ? ST_SETUP : ST_READ;
            ST_SETUP: if (stb_end) st_nxt = (at_a1 && cap_data == CMD_KEY1) ? ST_U3 : ST_READ;
            ST_U3:    if (stb_end) st_nxt = (at_a2 && cap_data == CMD_KEY2) ? ST_U4 : ST_READ;
            ST_U4: begin
                if (stb_end) begin
                    if (cap_data == CMD_SECTOR) begin
                        st_nxt   = ST_WINDOW;
                        sel_nxt  = sec_bit;
                        win_load = 1'b1;
                    end else begin
                        st_nxt = ST_READ;
                    end
                end
            end
            ST_WINDOW: begin
                if (stb_start) win_load = 1'b1;
                if (stb_end && cap_data == CMD_SECTOR) begin
                    sel_nxt  = sel | sec_bit;
                    win_load = 1'b1;
                end
                if (win_done && !win_load) begin
                    st_nxt   = ST_ERASE;
                    ers_load = 1'b1;
                end
            end
            ST_ERASE: begin
                if (stb_end && cap_data == CMD_SUSPEND) begin
                    st_nxt = ST_SUSP;
                end else if (ers_done) begin
                    st_nxt  = ST_READ;
                    sel_nxt = '0;
                end
            end
            ST_SUSP:  if (stb_end && cap_data == CMD_SECTOR) st_nxt = ST_ERASE;
            default:  begin st_nxt = ST_READ; sel_nxt = '0; end
        endcase
    end

    // State and selection registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_READ;
            sel   <= '0;
        end else begin
            state <= st_nxt;
            sel   <= sel_nxt;
        end
    end

endmodule

// File: rtl/flash_status_out.sv
// Read-data multiplexer. In status mode bit 7 reads 0 and bit 6 is a
// toggle that inverts on each read pulse; otherwise array data passes.
// Assumes: rd_stb is one cycle per read access.
module flash_status_out (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       status_mode,
    input  logic       rd_stb,
    input  logic [7:0] array_dq,
    output logic [7:0] dout
);

    logic tog;

    // Invert the toggle bit on each status read.
    always_ff @(posedge clk) begin
        if (!rst_n)                     tog <= 1'b0;
        else if (status_mode && rd_stb) tog <= ~tog;
    end

    // Select status or array data.
    always_comb begin
        if (status_mode) dout = {1'b0, tog, array_dq[5:0]};
        else             dout = array_dq;
    end

endmodule

// File: rtl/flash_erase_seq.sv
// Top of the sector-erase sequencer: strobe detection, command FSM,
// accept-window and erase-duration timers, status read path.
// Assumes: NSECT is a power of two and AW >= 12.
module flash_erase_seq
    import flash_erase_pkg::*;
#(
    parameter int          AW        = 12,
    parameter int          NSECT     = 8,
    parameter int          CLK_MHZ   = 250,
    parameter int          WIN_US    = 80,
    parameter int          ERASE_CYC = 50000,
    parameter logic [11:0] UNL_A1    = 12'h555,
    parameter logic [11:0] UNL_A2    = 12'h2AA
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ce_n,
    input  logic             we_n,
    input  logic [AW-1:0]    addr,
    input  logic [7:0]       wdata,
    input  logic             rd_stb,
    input  logic [7:0]       array_dq,
    input  logic [NSECT-1:0] wp_mask,
    output logic [7:0]       dout,
    output logic             ry_by_n,
    output logic             erase_run,
    output logic [NSECT-1:0] erase_sel
);

    localparam int WIN_CYC = CLK_MHZ * WIN_US;

    logic             stb_start;
    logic             stb_end;
    logic [AW-1:0]    cap_addr;
    logic [7:0]       cap_data;
    logic             win_load;
    logic             win_done;
    logic             ers_load;
    logic             ers_done;
    logic             busy;
    seq_st_t          state;
    logic [NSECT-1:0] sel;

    flash_bus_strobe #(.AW(AW)) u_stb (
        .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .we_n(we_n),
        .addr(addr), .wdata(wdata),
        .stb_start(stb_start), .stb_end(stb_end),
        .cap_addr(cap_addr), .cap_data(cap_data)
    );

    flash_cmd_fsm #(.AW(AW), .NSECT(NSECT), .UNL_A1(UNL_A1), .UNL_A2(UNL_A2)) u_fsm (
        .clk(clk), .rst_n(rst_n),
        .stb_start(stb_start), .stb_end(stb_end),
        .cap_addr(cap_addr), .cap_data(cap_data),
        .win_done(win_done), .ers_done(ers_done),
        .state(state), .sel(sel),
        .win_load(win_load), .ers_load(ers_load)
    );

    flash_down_timer #(.MAX(WIN_CYC)) u_win (
        .clk(clk), .rst_n(rst_n), .load(win_load),
        .run(state == ST_WINDOW), .done(win_done)
    );

    flash_down_timer #(.MAX(ERASE_CYC)) u_ers (
        .clk(clk), .rst_n(rst_n), .load(ers_load),
        .run(state == ST_ERASE), .done(ers_done)
    );

    assign busy      = (state == ST_WINDOW) || (state == ST_ERASE);
    assign ry_by_n   = ~busy;
    assign erase_run = (state == ST_ERASE);
    assign erase_sel = sel & ~wp_mask;

    flash_status_out u_out (
        .clk(clk), .rst_n(rst_n), .status_mode(busy),
        .rd_stb(rd_stb), .array_dq(array_dq), .dout(dout)
    );

endmodule

// File: rtl/flash_erase_seq_chk.sv
// Property checker for the sector-erase sequencer, bound to the top.
// Assumes: wp_mask is static while an erase runs.
module flash_erase_seq_chk #(
    parameter int NSECT = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             rd_stb,
    input logic [7:0]       dout,
    input logic             ry_by_n,
    input logic             erase_run,
    input logic [NSECT-1:0] erase_sel
);

    AST_RUN_IS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        erase_run |-> !ry_by_n); // R8

    AST_SEL_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        (erase_run && $past(erase_run)) |-> $stable(erase_sel)); // R6

    AST_DQ7_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        !ry_by_n |-> !dout[7]); // R7

    AST_TOGGLE_FLIP: assert property (@(posedge clk) disable iff (!rst_n)
        (!ry_by_n && $past(!ry_by_n) && $past(rd_stb)) |-> (dout[6] != $past(dout[6]))); // R7

endmodule

bind flash_erase_seq flash_erase_seq_chk #(.NSECT(NSECT)) u_chk (
    .clk(clk), .rst_n(rst_n), .rd_stb(rd_stb), .dout(dout),
    .ry_by_n(ry_by_n), .erase_run(erase_run), .erase_sel(erase_sel)
);

// File: tb/flash_erase_seq_bench.sv
// Scoreboard bench: tasks push expected values, a monitor compares at negedge.
module flash_erase_seq_bench;

    localparam int AW    = 12;
    localparam int NSECT = 8;
    localparam int ECYC  = 200;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             ce_n = 1'b1;
    logic             we_n = 1'b1;
    logic [AW-1:0]    addr = '0;
    logic [7:0]       wdata = '0;
    logic             rd_stb = 1'b0;
    logic [7:0]       array_dq = 8'hC3;
    logic [NSECT-1:0] wp_mask = 8'b1000_0000;
    logic [7:0]       dout;
    logic             ry_by_n;
    logic             erase_run;
    logic [NSECT-1:0] erase_sel;

    int checks = 0;
    int fails  = 0;
    int cycles = 0;

    typedef struct {
        int    kind;
        int    exp;
        string req;
    } exp_t;

    exp_t sb[$];

    always #2 clk = ~clk;

    flash_erase_seq #(.AW(AW), .NSECT(NSECT), .CLK_MHZ(1), .WIN_US(80), .ERASE_CYC(ECYC)) u_flash_erase_seq (
        .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .we_n(we_n), .addr(addr),
        .wdata(wdata), .rd_stb(rd_stb), .array_dq(array_dq), .wp_mask(wp_mask),
        .dout(dout), .ry_by_n(ry_by_n), .erase_run(erase_run), .erase_sel(erase_sel)
    );

    // kinds: 0 ry_by_n, 1 erase_sel, 2 erase_run, 3 dout
    task automatic expect_val(input int kind, input int exp, input string req);
        exp_t e;
        e.kind = kind; e.exp = exp; e.req = req;
        sb.push_back(e);
    endtask

    task automatic expect_idle(input string req);
        expect_val(0, 1, req);
        expect_val(1, 0, req);
        expect_val(2, 0, req);
        expect_val(3, 8'hC3, req);
    endtask

    // Monitor: compare every queued expectation away from the active edge.
    always @(negedge clk) begin
        while (sb.size() > 0) begin
            exp_t e;
            int act;
            e = sb.pop_front();
            case (e.kind)
                0:       act = int'(ry_by_n);
                1:       act = int'(erase_sel);
                2:       act = int'(erase_run);
                default: act = int'(dout);
            endcase
            checks++;
            if (act != e.exp) begin
                fails++;
                $display("FAIL %s kind=%0d actual=%0h expected=%0h", e.req, e.kind, act, e.exp);
            end
        end
    end

    task automatic idle(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    // One bus write; the address changes mid-strobe, the data is held to the end.
    task automatic bus_write(input logic [AW-1:0] a, input logic [7:0] d);
        @(posedge clk); #1;
        ce_n = 1'b0; we_n = 1'b0; addr = a; wdata = d;
        repeat (2) @(posedge clk);
        #1 addr = ~a;
        @(posedge clk); #1 we_n = 1'b1;
        @(posedge clk); #1 ce_n = 1'b1; wdata = 8'h00;
        idle(2);
    endtask

    task automatic unlock_and_sector(input logic [AW-1:0] sa);
        bus_write(12'h555, 8'hAA);
        bus_write(12'h2AA, 8'h55);
        bus_write(12'h555, 8'h80);
        bus_write(12'h555, 8'hAA);
        bus_write(12'h2AA, 8'h55);
        bus_write(sa, 8'h30);
    endtask

    task automatic read_pulse();
        @(posedge clk); #1 rd_stb = 1'b1;
        @(posedge clk); #1 rd_stb = 1'b0;
    endtask

    task automatic finish_run();
        idle(3);
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    endtask

    // Watchdog: a hung run counts as a failed check.
    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=%0d expected<150000", cycles);
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        idle(4);
        rst_n = 1'b1;
        idle(1);
        expect_idle("R1");
        idle(2);

        // R3: a wrong data byte at the fifth step, then a sector write
        bus_write(12'h555, 8'hAA);
        bus_write(12'h2AA, 8'h55);
        bus_write(12'h555, 8'h80);
        bus_write(12'h555, 8'hAA);
        bus_write(12'h2AA, 8'h12);
        bus_write(12'h600, 8'h30);
        expect_val(0, 1, "R3"); expect_val(1, 0, "R3");
        // R3: a wrong address at the second step
        bus_write(12'h555, 8'hAA);
        bus_write(12'h2AB, 8'h55);
        bus_write(12'h555, 8'h80);
        expect_val(0, 1, "R3"); expect_val(1, 0, "R3");
        idle(2);

        // R2: full sequence, sector 3 (address 600h)
        unlock_and_sector(12'h600);
        expect_val(0, 0, "R2"); expect_val(1, 8'h08, "R2"); expect_val(2, 0, "R2");
        expect_val(3, 8'h03, "R7");
        idle(1);
        read_pulse();
        expect_val(3, 8'h43, "R7");
        idle(1);
        read_pulse();
        expect_val(3, 8'h03, "R7");

        // R4, R9: add sectors 5, 0 and 7 (7 is protected)
        bus_write(12'hA00, 8'h30);
        bus_write(12'h000, 8'h30);
        bus_write(12'hE00, 8'h30);
        expect_val(1, 8'h29, "R4");
        expect_val(1, 8'h29, "R9");

        // R5: a late write restarts the window
        idle(60);
        expect_val(2, 0, "R5");
        bus_write(12'h200, 8'h30);
        expect_val(1, 8'h2B, "R4");
        idle(60);
        expect_val(2, 0, "R5"); expect_val(0, 0, "R5");
        idle(30);
        expect_val(2, 1, "R5"); expect_val(0, 0, "R5");

        // R6, R11: a sector write and a full new sequence during the erase
        bus_write(12'hC00, 8'h30);
        expect_val(1, 8'h2B, "R6");
        unlock_and_sector(12'hC00);
        expect_val(1, 8'h2B, "R11"); expect_val(2, 1, "R11");
        idle(100);
        expect_val(2, 1, "R11");
        idle(80);
        expect_idle("R8");
        idle(2);

        // R10: suspend freezes the count, resume continues it
        unlock_and_sector(12'h400);
        idle(90);
        expect_val(2, 1, "R10");
        idle(50);
        bus_write(12'h400, 8'hB0);
        expect_val(2, 0, "R10"); expect_val(0, 1, "R10");
        expect_val(3, 8'hC3, "R10"); expect_val(1, 8'h04, "R10");
        idle(300);
        expect_val(2, 0, "R10"); expect_val(1, 8'h04, "R10");
        bus_write(12'h400, 8'h30);
        idle(80);
        expect_val(2, 1, "R10"); expect_val(0, 0, "R10");
        idle(100);
        expect_idle("R8");

        finish_run();
    end

endmodule